// File: doc/BRIEF.md
# Per-Destination Output Queue Manager

This block sits at the end of a packet switching pipeline. It takes a single AXI4-Stream of packets in which an earlier stage has already written a destination bitmap into `tuser`. Bit q of that bitmap selects queue q. Each queue is a packet FIFO that drains to its own AXI4-Stream output. Queue indices are interleaved: even indices (0, 2, 4) feed physical Ethernet ports and odd indices (1, 3) feed DMA paths.

The keep-or-drop decision is made once per packet, on its first beat. If every selected queue has room for one packet of maximum size, the packet is written to all of them in parallel. If any one of them lacks that room, the whole packet is discarded, and the drop counter of each selected queue goes up by one. The input has no ready signal: discarded beats are swallowed at line rate. An output raises `tvalid` only when its queue holds at least one complete packet. A partly written packet therefore never starts out of a port.

Top module: `egress_queue_mgr`

## Requirements
- R1: After reset, every `m_tvalid` bit is 0 and every drop counter reads 0.
- R2: A packet whose first-beat `s_tuser` has only bit q set comes out of output q with the same data words, in the same order, and with `tlast` on its final beat only.
- R3: A packet whose first-beat `s_tuser` has several bits set is copied in full to every selected output.
- R4: A queue has room when its fill level is at most DEPTH − MAX_PKT words. If any selected queue lacks room at the first beat, the packet reaches no output, and each selected queue's 16-bit drop counter (queue q at bits 16q+15..16q of `drop_cnt`) rises by one. A queue never holds more than DEPTH words.
- R5: `s_tuser` on beats after the first has no effect on where the packet goes.
- R6: `m_tvalid[q]` is 1 exactly when queue q holds at least one complete packet. It rises in the cycle after the final beat is accepted.
- R7: While `m_tvalid[q]` is 1 and `m_tready[q]` is 0, `m_tvalid[q]`, the data and `m_tlast[q]` hold steady.
- R8: A packet with `s_tuser` all zero on its first beat is discarded and no drop counter changes.
- R9: The input takes a beat on every cycle `s_tvalid` is 1, including back-to-back packets, and writes only on such cycles.
- R10: A stalled output does not block admission to, or draining of, the other queues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_tdata | input | DW | Input data beat |
| s_tvalid | input | 1 | Input beat present |
| s_tlast | input | 1 | Final beat of packet |
| s_tuser | input | NQ | Destination bitmap, sampled on first beat |
| m_tdata | output | NQ*DW | Per-queue output data, queue q at bits q*DW upward |
| m_tvalid | output | NQ | Per-queue output valid |
| m_tready | input | NQ | Per-queue downstream ready |
| m_tlast | output | NQ | Per-queue final-beat flag |
| drop_cnt | output | NQ*16 | Per-queue dropped-packet counters |

## Verification
Some properties are checked on every cycle. The write mask on a first beat is either empty or equal to the destination bitmap. The mask stays fixed for the rest of the packet, and writes happen only on valid beats. No queue level goes past its depth, and a stalled output holds its beat. Other behaviour shows up only in the bench's scenarios: data order and integrity, exact drop counts at the room threshold, delayed visibility of packets split by idle cycles, and independence between a stalled queue and a draining one. The bench checks these against a model that tracks every queue's level and contents.

// File: rtl/eqm_pkg.sv
// Shared constants for the output queue manager.
// Assumes nothing beyond a standard SystemVerilog package scope.
package eqm_pkg;
    localparam int DROP_W = 16;
    typedef logic [DROP_W-1:0] drop_cnt_t;

    // Interleaved queue numbering: odd indices serve DMA paths.
    function automatic logic is_dma_queue(input int q);
        return q[0];
    endfunction
endpackage

// File: rtl/eqm_pkt_fifo.sv
// Packet FIFO for one destination queue.
// Stores {last, data} per word and counts complete packets held.
// The output is valid only while a complete packet is stored.
// Assumes DEPTH is a power of two and that the writer never overfills it.
module eqm_pkt_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 64,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_last,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] out_data,
    output logic          out_last,
    output logic [PW:0]   level
);
    logic [DW:0]   mem [DEPTH];
    logic [PW-1:0] wptr, rptr;
    logic [PW:0]   pkt_cnt;
    logic          pop, push_last, pop_last;

    assign out_valid = (pkt_cnt != '0);
    assign {out_last, out_data} = mem[rptr];
    assign pop       = out_valid && out_ready;
    assign push_last = wr_en && wr_last;
    assign pop_last  = pop && out_last;

    // Storage write, no reset needed for the array.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wptr] <= {wr_last, wr_data};
    end

    // Pointer, level and complete-packet bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr    <= '0;
            rptr    <= '0;
            level   <= '0;
            pkt_cnt <= '0;
        end else begin
            if (wr_en) wptr <= wptr + 1'b1;
            if (pop)   rptr <= rptr + 1'b1;
            case ({wr_en, pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
            case ({push_last, pop_last})
                2'b10:   pkt_cnt <= pkt_cnt + 1'b1;
                2'b01:   pkt_cnt <= pkt_cnt - 1'b1;
                default: pkt_cnt <= pkt_cnt;
            endcase
        end
    end
endmodule

// File: rtl/eqm_admit.sv
// Admission control for the queue manager.
// On the first beat of a packet it checks every selected queue for room
// (level <= DEPTH - MAX_PKT) and either accepts the packet into all of them
// or drops it whole. The mask chosen is held until the final beat.
// Assumes no packet is longer than MAX_PKT beats.
module eqm_admit
    import eqm_pkg::*;
#(
    parameter int NQ      = 5,
    parameter int DEPTH   = 64,
    parameter int MAX_PKT = 16,
    localparam int PW     = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 s_tvalid,
    input  logic                 s_tlast,
    input  logic [NQ-1:0]        s_tuser,
    input  logic [NQ*(PW+1)-1:0] q_level,
    output logic [NQ-1:0]        wr_en,
    output logic                 pkt_open,
    output logic [NQ*DROP_W-1:0] drop_cnt
);
    localparam logic [PW:0] ROOM_LIMIT = (PW+1)'(DEPTH - MAX_PKT);

    logic [NQ-1:0] room, held_mask, new_mask;
    logic          first_beat, accept;

    // Per-queue room flag from the current fill level.
    for (genvar q = 0; q < NQ; q++) begin : g_room
        assign room[q] = q_level[q*(PW+1) +: (PW+1)] <= ROOM_LIMIT;
    end

    assign first_beat = s_tvalid && !pkt_open;
    assign accept     = ((s_tuser & ~room) == '0);
    assign new_mask   = accept ? s_tuser : '0;

    // Write enables: fresh decision on the first beat, held mask after.
    always_comb begin
        wr_en = '0;
        if (s_tvalid) wr_en = pkt_open ? held_mask : new_mask;
    end

    // Packet framing and mask hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pkt_open  <= 1'b0;
            held_mask <= '0;
        end else if (s_tvalid) begin
            pkt_open <= !s_tlast;
            if (!pkt_open) held_mask <= new_mask;
        end
    end

    // Per-queue drop counters, bumped once per rejected packet.
    for (genvar q = 0; q < NQ; q++) begin : g_drop
        drop_cnt_t cnt;
        always_ff @(posedge clk) begin
            if (!rst_n)                                  cnt <= '0;
            else if (first_beat && !accept && s_tuser[q]) cnt <= cnt + 1'b1;
        end
        assign drop_cnt[q*DROP_W +: DROP_W] = cnt;
    end
endmodule

// File: rtl/egress_queue_mgr.sv
// Top of the per-destination output queue manager.
// One input stream, NQ packet queues, one output stream per queue.
// Even queue indices serve Ethernet ports, odd ones DMA paths.
// Assumes packets are at most MAX_PKT beats and DEPTH is a power of two
// with DEPTH >= MAX_PKT.
module egress_queue_mgr
    import eqm_pkg::*;
#(
    parameter int NQ      = 5,
    parameter int DW      = 32,
    parameter int DEPTH   = 64,
    parameter int MAX_PKT = 16,
    localparam int PW     = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DW-1:0]        s_tdata,
    input  logic                 s_tvalid,
    input  logic                 s_tlast,
    input  logic [NQ-1:0]        s_tuser,
    output logic [NQ*DW-1:0]     m_tdata,
    output logic [NQ-1:0]        m_tvalid,
    input  logic [NQ-1:0]        m_tready,
    output logic [NQ-1:0]        m_tlast,
    output logic [NQ*DROP_W-1:0] drop_cnt
);
    logic [NQ-1:0]        wr_en;
    logic                 pkt_open;
    logic [NQ*(PW+1)-1:0] q_level;

    eqm_admit #(.NQ(NQ), .DEPTH(DEPTH), .MAX_PKT(MAX_PKT)) admit_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .s_tvalid (s_tvalid),
        .s_tlast  (s_tlast),
        .s_tuser  (s_tuser),
        .q_level  (q_level),
        .wr_en    (wr_en),
        .pkt_open (pkt_open),
        .drop_cnt (drop_cnt)
    );

    // One packet FIFO per destination, all fed from the same input beat.
    for (genvar q = 0; q < NQ; q++) begin : g_queue
        eqm_pkt_fifo #(.DW(DW), .DEPTH(DEPTH)) fifo_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (wr_en[q]),
            .wr_data   (s_tdata),
            .wr_last   (s_tlast),
            .out_valid (m_tvalid[q]),
            .out_ready (m_tready[q]),
            .out_data  (m_tdata[q*DW +: DW]),
            .out_last  (m_tlast[q]),
            .level     (q_level[q*(PW+1) +: (PW+1)])
        );
    end
endmodule

// File: rtl/eqm_checker.sv
// Cycle-level properties of the output queue manager, bound to its top.
module eqm_checker #(
    parameter int NQ    = 5,
    parameter int DW    = 32,
    parameter int DEPTH = 64,
    localparam int PW   = $clog2(DEPTH)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 s_tvalid,
    input logic [NQ-1:0]        s_tuser,
    input logic [NQ-1:0]        wr_en,
    input logic                 pkt_open,
    input logic [NQ*DW-1:0]     m_tdata,
    input logic [NQ-1:0]        m_tvalid,
    input logic [NQ-1:0]        m_tready,
    input logic [NQ-1:0]        m_tlast,
    input logic [NQ*(PW+1)-1:0] q_level
);
    logic [NQ-1:0] seen_mask;

    // Mask observed on the first beat of the current packet.
    always_ff @(posedge clk) begin
        if (!rst_n)                      seen_mask <= '0;
        else if (s_tvalid && !pkt_open)  seen_mask <= wr_en;
    end

    // R3/R4: first beat writes everything selected or nothing.
    a_r3_all_or_none: assert property (@(posedge clk) disable iff (!rst_n)
        (s_tvalid && !pkt_open) |-> (wr_en == '0 || wr_en == s_tuser));

    // R5: later beats follow the first-beat mask.
    a_r5_mask_held: assert property (@(posedge clk) disable iff (!rst_n)
        (s_tvalid && pkt_open) |-> (wr_en == seen_mask));

    // R9: writes only on valid input beats.
    a_r9_write_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en != '0) |-> s_tvalid);

    for (genvar q = 0; q < NQ; q++) begin : g_q
        // R4: a queue never exceeds its depth.
        a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
            q_level[q*(PW+1) +: (PW+1)] <= (PW+1)'(DEPTH));

        // R7: a stalled output holds its beat.
        a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (m_tvalid[q] && !m_tready[q]) |=>
            (m_tvalid[q] && $stable(m_tdata[q*DW +: DW]) && $stable(m_tlast[q])));
    end
endmodule

bind egress_queue_mgr eqm_checker #(.NQ(NQ), .DW(DW), .DEPTH(DEPTH)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .s_tvalid (s_tvalid),
    .s_tuser  (s_tuser),
    .wr_en    (wr_en),
    .pkt_open (pkt_open),
    .m_tdata  (m_tdata),
    .m_tvalid (m_tvalid),
    .m_tready (m_tready),
    .m_tlast  (m_tlast),
    .q_level  (q_level)
);

// File: tb/egress_queue_mgr_tb_top.sv
// Self-checking bench: directed corner cases plus seeded random traffic,
// compared against a per-queue level and content model.
module egress_queue_mgr_tb_top;
    localparam int NQ = 5, DW = 32, DEPTH = 64, MAX_PKT = 16, CW = 16;
    localparam int SB = 2048;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [DW-1:0]      s_tdata = '0;
    logic               s_tvalid = 1'b0, s_tlast = 1'b0;
    logic [NQ-1:0]      s_tuser = '0;
    logic [NQ*DW-1:0]   m_tdata;
    logic [NQ-1:0]      m_tvalid, m_tlast;
    logic [NQ-1:0]      m_tready = '0;
    logic [NQ*CW-1:0]   drop_cnt;

    always #5 clk = ~clk;

    egress_queue_mgr #(.NQ(NQ), .DW(DW), .DEPTH(DEPTH), .MAX_PKT(MAX_PKT)) dut_i (
        .clk(clk), .rst_n(rst_n), .s_tdata(s_tdata), .s_tvalid(s_tvalid),
        .s_tlast(s_tlast), .s_tuser(s_tuser), .m_tdata(m_tdata),
        .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tlast(m_tlast),
        .drop_cnt(drop_cnt)
    );

    int n_vec = 0, n_bad = 0;
    bit done = 0;

    // Model state.
    logic [DW:0]   exp_mem [NQ][SB];
    int            head [NQ], tail [NQ], lvl [NQ], pkts [NQ], drops [NQ];
    bit            in_pkt = 0;
    logic [NQ-1:0] cur_mask = '0;
    int            rdy_mode = 2;      // 0 random, 1 all low, 2 all high, 3 only q0
    logic [DW-1:0] seq = 32'h1000;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic bit has_room(input int q);
        return lvl[q] <= DEPTH - MAX_PKT;
    endfunction

    // One clock of stimulus plus model update and output checks.
    task automatic cycle(input bit v, input logic [DW-1:0] d, input bit l, input logic [NQ-1:0] u);
        logic [NQ-1:0] mask;
        @(negedge clk);
        for (int q = 0; q < NQ; q++) begin
            chk(m_tvalid[q] == (pkts[q] > 0), "R6 valid vs complete packets", m_tvalid[q], pkts[q] > 0);
            chk(drop_cnt[q*CW +: CW] == CW'(drops[q]), "R4 drop counter", drop_cnt[q*CW +: CW], drops[q]);
        end
        s_tvalid = v; s_tdata = d; s_tlast = l; s_tuser = u;
        for (int q = 0; q < NQ; q++) begin
            case (rdy_mode)
                0: m_tready[q] = ($urandom_range(0, 9) < 7);
                1: m_tready[q] = 1'b0;
                2: m_tready[q] = 1'b1;
                default: m_tready[q] = (q == 0);
            endcase
        end
        #1;
        mask = cur_mask;
        if (v && !in_pkt) begin
            bit ok = 1;
            for (int q = 0; q < NQ; q++) if (u[q] && !has_room(q)) ok = 0;
            mask = ok ? u : '0;
            if (!ok) for (int q = 0; q < NQ; q++) if (u[q]) drops[q]++;
            cur_mask = mask;
        end
        for (int q = 0; q < NQ; q++) begin
            if (m_tvalid[q] && m_tready[q]) begin
                if (lvl[q] == 0) chk(0, "R2 unexpected output beat", m_tdata[q*DW +: DW], 0);
                else begin
                    chk({m_tlast[q], m_tdata[q*DW +: DW]} == exp_mem[q][head[q]],
                        "R2 output beat", {m_tlast[q], m_tdata[q*DW +: DW]}, exp_mem[q][head[q]]);
                    if (exp_mem[q][head[q]][DW]) pkts[q]--;
                    head[q] = (head[q] + 1) % SB;
                    lvl[q]--;
                end
            end
        end
        if (v) begin
            for (int q = 0; q < NQ; q++) if (mask[q]) begin
                exp_mem[q][tail[q]] = {l, d};
                tail[q] = (tail[q] + 1) % SB;
                lvl[q]++;
                if (l) pkts[q]++;
            end
            in_pkt = !l;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cycle(0, '0, 0, '0);
    endtask

    // Send one packet; gaps inserts random idle cycles, mid_user scrambles later tuser.
    task automatic send(input int len, input logic [NQ-1:0] u, input bit gaps, input bit mid_user);
        for (int i = 0; i < len; i++) begin
            logic [NQ-1:0] uu;
            uu = (i == 0 || !mid_user) ? u : NQ'($urandom);
            seq = seq + 32'h1;
            cycle(1, seq ^ 32'hA5000000, i == len - 1, uu);
            if (gaps && i != len - 1 && $urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
        end
    endtask

    task automatic drained(input string req);
        int tot;
        rdy_mode = 2;
        idle(2 * DEPTH + 4);
        tot = 0;
        for (int q = 0; q < NQ; q++) tot += lvl[q];
        chk(tot == 0 && m_tvalid == '0, req, m_tvalid, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int q = 0; q < NQ; q++) begin
            head[q] = 0; tail[q] = 0; lvl[q] = 0; pkts[q] = 0; drops[q] = 0;
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state.
        chk(m_tvalid == '0, "R1 valid after reset", m_tvalid, 0);
        chk(drop_cnt == '0, "R1 drop counters after reset", drop_cnt, 0);

        // R2: each queue alone.
        rdy_mode = 2;
        for (int q = 0; q < NQ; q++) send(3, NQ'(1) << q, 0, 0);
        drained("R2 single-destination packets delivered");

        // R3: broadcast to all queues.
        send(4, '1, 0, 0);
        send(2, 5'b01010, 0, 0);
        drained("R3 multi-destination copies delivered");

        // R6: packet split by idle cycles stays hidden until its last beat.
        send(MAX_PKT, 5'b00010, 1, 0);
        drained("R6 gapped packet delivered");

        // R5: later-beat tuser ignored.
        send(6, 5'b00100, 0, 1);
        send(6, 5'b00000, 0, 1);
        drained("R5 later tuser ignored");

        // R8: empty destination discarded.
        send(5, '0, 0, 0);
        drained("R8 null destination discarded");

        // R4: fill queue 2 with outputs stalled; fifth packet dropped.
        rdy_mode = 1;
        for (int i = 0; i < DEPTH / MAX_PKT + 1; i++) send(MAX_PKT, 5'b00100, 0, 0);
        send(3, 5'b01100, 0, 0);
        idle(2);
        chk(drop_cnt[2*CW +: CW] == 16'd2, "R4 queue 2 drops at threshold", drop_cnt[2*CW +: CW], 2);
        chk(drop_cnt[3*CW +: CW] == 16'd1, "R4 queue 3 drop from shared reject", drop_cnt[3*CW +: CW], 1);

        // R10: queue 0 drains while queue 2 stays full.
        rdy_mode = 3;
        send(4, 5'b00001, 0, 0);
        idle(8);
        chk(m_tvalid[2] == 1'b1 && lvl[0] == 0, "R10 queue 0 drained past stall", lvl[0], 0);
        drained("R4 stalled queue released");

        // R9: back-to-back packets with no idle cycles.
        for (int i = 0; i < 8; i++) send(1 + i, 5'b10001, 0, 0);
        drained("R9 back-to-back packets");

        // Random traffic.
        rdy_mode = 0;
        for (int i = 0; i < 2500; i++) begin
            logic [NQ-1:0] u;
            u = ($urandom_range(0, 9) == 0) ? '0 : NQ'($urandom);
            send($urandom_range(1, MAX_PKT), u, $urandom_range(0, 4) == 0, $urandom_range(0, 1));
            if ($urandom_range(0, 5) == 0) idle($urandom_range(1, 4));
        end
        drained("R2 random traffic drained");

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule